// File: doc/BRIEF.md
# Irregular Sequence State Counter

A 3-bit synchronous state counter that steps through the fixed, non-binary loop 001, 010, 101, 111 and then starts again at 001. All state bits are clocked by one clock, and the next state is a function of the present state alone. The counter advances only on clock edges where the enable input is high. A synchronous clear input returns it to the start of the loop.

The four codes outside the loop are 000, 011, 100 and 110. None of them is a step in the sequence. Each one leads straight back to 001 on the next enabled edge, so the counter cannot lock up. A flag output is high while the state is one of the four loop codes.

The code loaded by the asynchronous reset is a parameter. Its default is 001, which is the start of the loop.

Top module: `seq_cnt`

## Requirements
- R1: While rst_ni is low, state_o equals the parameter RESET_CODE, whose default is 001. valid_o matches that code.
- R2: With en_i high and clr_i low, state 001 goes to 010 on the next clock edge.
- R3: With en_i high and clr_i low, state 010 goes to 101 on the next clock edge.
- R4: With en_i high and clr_i low, state 101 goes to 111 on the next clock edge.
- R5: With en_i high and clr_i low, state 111 goes to 001 on the next clock edge, and the loop repeats.
- R6: With en_i high and clr_i low, each unused code (000, 011, 100, 110) goes to 001 on the next clock edge.
- R7: With en_i low and clr_i low, the state holds across a clock edge. This includes an unused code.
- R8: valid_o is high exactly when state_o is 001, 010, 101 or 111. Once it is high, it stays high until the next reset.
- R9: With clr_i high, the next clock edge loads 001 whatever the value of en_i and whatever the present state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low; loads RESET_CODE |
| clr_i | input | 1 | Synchronous clear to 001; overrides en_i |
| en_i | input | 1 | Advance enable |
| state_o | output | 3 | Present state code |
| valid_o | output | 1 | High while the state is a loop code |

## Verification
The bench builds one instance for each unused code as its reset value, alongside the default instance. This lets it test lock-up recovery through the ports.

A design that counted an unused code onward in binary, or treated it as a step in the loop, would miss 001 on the first enabled edge. A design that recovered while disabled would fail the hold check made on those same codes. Irregular enable patterns and clear pulses, some of them with enable low, also target three more faults: a clear that waits for enable, a valid flag decoded from the wrong codes, and any of the four loop steps being swapped.

// File: rtl/seq_cnt_pkg.sv
package seq_cnt_pkg;
  localparam int unsigned StateW  = 3;
  localparam int unsigned LoopLen = 4;

  typedef logic [StateW-1:0] code_t;

  localparam code_t CodeA = 3'b001;
  localparam code_t CodeB = 3'b010;
  localparam code_t CodeC = 3'b101;
  localparam code_t CodeD = 3'b111;

  localparam code_t LoopCodes [LoopLen] = '{CodeA, CodeB, CodeC, CodeD};
endpackage

// File: rtl/seq_cnt_next.sv
module seq_cnt_next
  import seq_cnt_pkg::*;
(
  input  code_t cur_i,
  output code_t nxt_o
);
  always_comb begin
    unique case (cur_i)
      CodeA:   nxt_o = CodeB;
      CodeB:   nxt_o = CodeC;
      CodeC:   nxt_o = CodeD;
      CodeD:   nxt_o = CodeA;
      default: nxt_o = CodeA; // unused codes re-enter the loop
    endcase
  end
endmodule

// File: rtl/seq_cnt_valid.sv
module seq_cnt_valid
  import seq_cnt_pkg::*;
(
  input  code_t state_i,
  output logic  valid_o
);
  logic [LoopLen-1:0] hit;

  for (genvar g = 0; g < LoopLen; g++) begin : g_match
    assign hit[g] = (state_i == LoopCodes[g]);
  end

  assign valid_o = |hit;
endmodule

// File: rtl/seq_cnt_reg.sv
module seq_cnt_reg
  import seq_cnt_pkg::*;
#(
  parameter code_t RESET_CODE = CodeA
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  clr_i,
  input  logic  en_i,
  input  code_t nxt_i,
  output code_t state_o
);
  code_t state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    state_q <= RESET_CODE;
    else if (clr_i) state_q <= CodeA;
    else if (en_i)  state_q <= nxt_i;
  end

  assign state_o = state_q;

  p_step_a_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !clr_i && state_q == CodeA) |=> state_q == CodeB);
  p_step_b_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !clr_i && state_q == CodeB) |=> state_q == CodeC);
  p_step_c_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !clr_i && state_q == CodeC) |=> state_q == CodeD);
  p_step_d_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !clr_i && state_q == CodeD) |=> state_q == CodeA);
  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !clr_i) |=> $stable(state_q));
  p_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> state_q == CodeA);
endmodule

// File: rtl/seq_cnt.sv
module seq_cnt
  import seq_cnt_pkg::*;
#(
  parameter code_t RESET_CODE = CodeA
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       en_i,
  output logic [2:0] state_o,
  output logic       valid_o
);
  code_t cur, nxt;

  seq_cnt_next u_next (
    .cur_i (cur),
    .nxt_o (nxt)
  );

  seq_cnt_reg #(.RESET_CODE(RESET_CODE)) u_reg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (clr_i),
    .en_i    (en_i),
    .nxt_i   (nxt),
    .state_o (cur)
  );

  seq_cnt_valid u_valid (
    .state_i (cur),
    .valid_o (valid_o)
  );

  assign state_o = cur;

  p_recover_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !clr_i && !valid_o) |=> state_o == CodeA);
  p_stay_valid_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> valid_o);
endmodule

// File: tb/tb_seq_cnt.sv
module tb_seq_cnt;
  localparam int ClkPeriod = 10;
  localparam int NumUnits  = 5;
  localparam logic [2:0] RstCodes [NumUnits] = '{3'd1, 3'd0, 3'd3, 3'd4, 3'd6};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr = 1'b0;
  logic en = 1'b0;
  logic [2:0] st [NumUnits];
  logic       vl [NumUnits];

  int checks = 0;
  int errors = 0;
  int model [NumUnits];
  int loop_q [$] = '{1, 2, 5, 7};
  int lcg = 12345;
  bit done = 1'b0;

  always #(ClkPeriod / 2) clk = ~clk;

  for (genvar g = 0; g < NumUnits; g++) begin : g_unit
    if (g == 0) begin : g_main
      seq_cnt dut (
        .clk_i(clk), .rst_ni(rst_n), .clr_i(clr), .en_i(en),
        .state_o(st[g]), .valid_o(vl[g])
      );
    end else begin : g_alt
      seq_cnt #(.RESET_CODE(RstCodes[g])) dut (
        .clk_i(clk), .rst_ni(rst_n), .clr_i(clr), .en_i(en),
        .state_o(st[g]), .valid_o(vl[g])
      );
    end
  end

  function automatic int loop_idx(int s);
    foreach (loop_q[i]) if (loop_q[i] == s) return i;
    return -1;
  endfunction

  function automatic int ref_next(int s, bit e, bit c);
    int i;
    if (c) return 1;
    if (!e) return s;
    i = loop_idx(s);
    if (i < 0) return 1;
    return loop_q[(i + 1) % loop_q.size()];
  endfunction

  function automatic string step_req(int s, bit e, bit c);
    if (c) return "R9";
    if (!e) return "R7";
    case (s)
      1: return "R2";
      2: return "R3";
      5: return "R4";
      7: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic compare_all(string req_for [NumUnits]);
    for (int u = 0; u < NumUnits; u++) begin
      bit exp_v;
      exp_v = (loop_idx(model[u]) >= 0);
      checks++;
      if (int'(st[u]) != model[u]) begin
        errors++;
        $display("FAIL %s unit %0d state actual=%0d expected=%0d", req_for[u], u, st[u], model[u]);
      end
      checks++;
      if (vl[u] != exp_v) begin
        errors++;
        $display("FAIL R8 unit %0d valid actual=%0b expected=%0b", u, vl[u], exp_v);
      end
    end
  endtask

  task automatic do_reset();
    string r [NumUnits];
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    for (int u = 0; u < NumUnits; u++) begin
      model[u] = int'(RstCodes[u]);
      r[u] = "R1";
    end
    compare_all(r);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic step(bit e, bit c);
    string r [NumUnits];
    en = e;
    clr = c;
    @(posedge clk);
    for (int u = 0; u < NumUnits; u++) begin
      r[u] = step_req(model[u], e, c);
      model[u] = ref_next(model[u], e, c);
    end
    @(negedge clk);
    compare_all(r);
  endtask

  initial begin
    for (int u = 0; u < NumUnits; u++) model[u] = int'(RstCodes[u]);
    repeat (2) @(negedge clk);
    do_reset();
    // R7: unused codes and the start code hold while disabled
    step(1'b0, 1'b0);
    step(1'b0, 1'b0);
    // R6 recovery for all unused codes, then R2..R5 around the loop
    for (int k = 0; k < 9; k++) step(1'b1, 1'b0);
    // R9 with enable low, and from each unused code
    do_reset();
    step(1'b0, 1'b1);
    step(1'b1, 1'b0);
    step(1'b1, 1'b1);
    step(1'b0, 1'b0);
    // irregular patterns
    for (int k = 0; k < 200; k++) begin
      bit e, c;
      lcg = lcg * 1103515245 + 12345;
      e = lcg[17] | lcg[20];
      c = (lcg[24:22] == 3'd0);
      step(e, c);
      if (k == 100) do_reset();
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule